// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

This block generates a pulse-width modulated waveform on each of four output pins. Each channel has a counter that repeats over a programmable period. A programmable duty value sets how long the output stays at its active level. A programmable prescaler slows the counter by a power of two, and a polarity bit chooses which level is the active one. Software starts and stops the channels through a pair of write-one registers: one sets the enable bits and the other clears them. A status word shows which channels are running.

While a channel runs, its mode, duty and period registers are frozen. Software changes the duty or the period of a running channel by writing a single update register. A mode bit decides whether that value targets the duty or the period. The value is held pending and is copied into place only on the counter's wrap cycle, so a waveform period is never cut short or stretched partway through. The register bus is a plain strobe interface: a write strobe with address and data, and a read strobe whose data appears on the following cycle.

Top module: `pwm_bank`

## Requirements
- R1: A write to byte address 0x04 sets the enable bit of every channel whose data bit [n] is 1. Data bits written as 0 leave the enable bits unchanged.
- R2: A write to byte address 0x08 clears the enable bit of every channel whose data bit [n] is 1. Data bits written as 0 leave the enable bits unchanged.
- R3: A read of byte address 0x0C returns the enable bits in [3:0] and zero in all other bits. Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is sampled high.
- R4: Channel n occupies the window starting at 0x200 + n*0x20. Inside the window, mode is at +0x00, duty at +0x04, period at +0x08 and update at +0x10. The update register always reads as zero.
- R5: Duty and period keep only the low 16 bits of the written data. Bits [31:16] of every read return zero.
- R6: Mode bits [3:0] select the prescaler exponent p, and a written value above 10 is stored as 10. Bit 9 is the polarity bit and bit 10 is the update target. Every other mode bit reads as zero.
- R7: The channel counter advances once every 2^p clock cycles and runs 0..period-1. The output is active while the counter is below duty, so each period holds min(duty, period)*2^p active cycles. A period of 0 gives a constantly active output.
- R8: With polarity 0 the active level is 1. With polarity 1 the active level is 0 and the idle level is 1.
- R9: A write to the update register stores a pending value. On the counter's wrap cycle, that value is copied into duty (mode bit 10 = 0) or into period (bit 10 = 1). A second write before the wrap replaces the first.
- R10: A disabled channel drives its idle level (equal to the polarity bit) and holds its counter at 0, so it restarts from 0 when enabled again.
- R11: Writes to the mode, duty and period registers take effect only while the channel is disabled. While the channel runs, such writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pwm_out | output | NCH (4) | Registered PWM outputs, one per channel |

## Verification
The bench uses the default parameters: four channels, a 12-bit address and a largest prescaler exponent of 10. With these values, prescaler settings of 0, 1 and 4 give periods from 4 to 160 clock cycles. That keeps active-cycle counts over whole periods short. It also lets the bench place an update write well before the first wrap and then read back both the old and the new duty. The clamp on exponents above 10, the clamp of duty to period, inverted polarity and buffered period changes are all reached with these defaults.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int BUS_W      = 32;
  localparam int VAL_W      = 16;
  localparam int PRES_W     = 4;

  localparam int OFF_ENA    = 'h04;
  localparam int OFF_DIS    = 'h08;
  localparam int OFF_STATUS = 'h0C;

  localparam int CH_BASE    = 'h200;
  localparam int STRIDE_LG  = 5;

  localparam int COFF_MODE  = 'h00;
  localparam int COFF_DUTY  = 'h04;
  localparam int COFF_PRD   = 'h08;
  localparam int COFF_UPD   = 'h10;

  localparam int BIT_POL    = 9;
  localparam int BIT_TGT    = 10;

  typedef struct packed {
    logic              upd_prd;
    logic              pol;
    logic [PRES_W-1:0] pres;
  } mode_t;

  function automatic logic [BUS_W-1:0] mode_word(mode_t m);
    logic [BUS_W-1:0] w;
    w = '0;
    w[PRES_W-1:0] = m.pres;
    w[BIT_POL]    = m.pol;
    w[BIT_TGT]    = m.upd_prd;
    return w;
  endfunction

endpackage

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc #(
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PRES_MAX:0] tick
);

  logic [PRES_MAX-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick[0] = 1'b1;

  for (genvar p = 1; p <= PRES_MAX; p++) begin : g_tick
    assign tick[p] = &div_q[p-1:0];
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan import pwm_bank_pkg::*; #(
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PRES_MAX:0] tick_vec,
  input  logic              wr_mode,
  input  logic              wr_duty,
  input  logic              wr_prd,
  input  logic              wr_upd,
  input  logic [BUS_W-1:0]  wdata,
  output mode_t             mode_o,
  output logic [VAL_W-1:0]  duty_o,
  output logic [VAL_W-1:0]  prd_o,
  output logic              pwm_o
);

  mode_t              mode_r;
  logic [VAL_W-1:0]   duty_r, prd_r, cnt_q, pend_d;
  logic               pend_v, pend_tgt, pwm_q;
  logic               tick, wrap, active;
  logic [PRES_W-1:0]  pres_in, pres_cl;

  assign pres_in = wdata[PRES_W-1:0];
  assign pres_cl = (32'(pres_in) > PRES_MAX) ? PRES_W'(PRES_MAX) : pres_in;

  assign tick   = tick_vec[mode_r.pres];
  assign wrap   = ({1'b0, cnt_q} + 17'd1) >= {1'b0, prd_r};
  assign active = (cnt_q < duty_r) || (duty_r >= prd_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r   <= '0;
      duty_r   <= '0;
      prd_r    <= '0;
      cnt_q    <= '0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
      pend_tgt <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      if (!en) begin
        cnt_q <= '0;
        if (wr_mode) begin
          mode_r.pres    <= pres_cl;
          mode_r.pol     <= wdata[BIT_POL];
          mode_r.upd_prd <= wdata[BIT_TGT];
        end
        if (wr_duty) duty_r <= wdata[VAL_W-1:0];
        if (wr_prd)  prd_r  <= wdata[VAL_W-1:0];
      end else if (tick) begin
        if (wrap) begin
          cnt_q <= '0;
          if (pend_v) begin
            if (pend_tgt) prd_r  <= pend_d;
            else          duty_r <= pend_d;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_upd) begin
        pend_v   <= 1'b1;
        pend_d   <= wdata[VAL_W-1:0];
        pend_tgt <= mode_r.upd_prd;
      end else if (en && tick && wrap) begin
        pend_v   <= 1'b0;
      end
      pwm_q <= (en && active) ? ~mode_r.pol : mode_r.pol;
    end
  end

  assign mode_o = mode_r;
  assign duty_o = duty_r;
  assign prd_o  = prd_r;
  assign pwm_o  = pwm_q;

  // R6: stored exponent never exceeds the largest supported one
  assert_pres_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    32'(mode_r.pres) <= PRES_MAX);

  // R7: a running counter stays inside the period
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    (en && prd_r != '0) |-> (cnt_q < prd_r));

  // R9 / R11: configuration of a running channel moves only on a wrap
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(tick && wrap)) |->
      ($stable(duty_r) && $stable(prd_r) && $stable(mode_r)));

  // R10: an idle channel drives its polarity bit
  assert_idle_out_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (pwm_q == $past(mode_r.pol)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank import pwm_bank_pkg::*; #(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 12,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int CIDX_W = ADDR_W - STRIDE_LG;

  logic [ADDR_W-1:0]    rel;
  logic [CIDX_W-1:0]    cidx;
  logic [STRIDE_LG-1:0] coff;
  logic                 ch_hit;
  logic [NCH-1:0]       en_q;
  logic [PRES_MAX:0]    tick_vec;
  logic [BUS_W-1:0]     rd_next;
  logic                 hit_ena, hit_dis;

  mode_t            mode_a [NCH];
  logic [VAL_W-1:0] duty_a [NCH];
  logic [VAL_W-1:0] prd_a  [NCH];

  assign rel     = bus_addr - ADDR_W'(CH_BASE);
  assign cidx    = rel[ADDR_W-1:STRIDE_LG];
  assign coff    = rel[STRIDE_LG-1:0];
  assign ch_hit  = (bus_addr >= ADDR_W'(CH_BASE)) && (32'(cidx) < NCH);
  assign hit_ena = bus_wr && (bus_addr == ADDR_W'(OFF_ENA));
  assign hit_dis = bus_wr && (bus_addr == ADDR_W'(OFF_DIS));

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (hit_ena) en_q <= en_q | bus_wdata[NCH-1:0];
    else if (hit_dis) en_q <= en_q & ~bus_wdata[NCH-1:0];
  end

  pwm_bank_presc #(.PRES_MAX(PRES_MAX)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_vec)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = bus_wr && ch_hit && (cidx == CIDX_W'(i));

    pwm_bank_chan #(.PRES_MAX(PRES_MAX)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (en_q[i]),
      .tick_vec (tick_vec),
      .wr_mode  (sel && coff == STRIDE_LG'(COFF_MODE)),
      .wr_duty  (sel && coff == STRIDE_LG'(COFF_DUTY)),
      .wr_prd   (sel && coff == STRIDE_LG'(COFF_PRD)),
      .wr_upd   (sel && coff == STRIDE_LG'(COFF_UPD)),
      .wdata    (bus_wdata),
      .mode_o   (mode_a[i]),
      .duty_o   (duty_a[i]),
      .prd_o    (prd_a[i]),
      .pwm_o    (pwm_out[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFF_STATUS)) rd_next[NCH-1:0] = en_q;
    if (ch_hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (cidx == CIDX_W'(i)) begin
          case (32'(coff))
            COFF_MODE: rd_next = mode_word(mode_a[i]);
            COFF_DUTY: rd_next = {{(BUS_W-VAL_W){1'b0}}, duty_a[i]};
            COFF_PRD:  rd_next = {{(BUS_W-VAL_W){1'b0}}, prd_a[i]};
            default:   rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R1: the enable bits change only in response to a bus write
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(en_q));

  // R2: channels named in a disable write are stopped
  assert_disable_clear_R2: assert property (@(posedge clk) disable iff (rst)
    hit_dis |=> ((en_q & $past(bus_wdata[NCH-1:0])) == '0));

  // R5: the upper half of every read word is zero
  assert_rdata_upper_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:VAL_W] == '0);

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [11:0] ca(int ch, int off);
    return 12'('h200 + ch * 'h20 + off);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push the expected word, then issue the read
  task automatic rd_exp(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic measure(int ch, int ncyc, output int hi);
    hi = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  // monitor: a read strobe seen at the edge yields data at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R10 reset pwm_out", int'(pwm_out), 0);
    rd_exp(12'h00C, 32'h0, "R3 reset status");
    rd_exp(ca(2, 'h04), 32'h0, "R4 reset duty");

    // channel setup while disabled (R4, R6, R8)
    wr(ca(0, 'h00), 32'h0000_0000); wr(ca(0, 'h04), 3); wr(ca(0, 'h08), 8);
    wr(ca(1, 'h00), 32'h0000_0001); wr(ca(1, 'h04), 2); wr(ca(1, 'h08), 5);
    wr(ca(2, 'h00), 32'h0000_0200); wr(ca(2, 'h04), 1); wr(ca(2, 'h08), 4);
    wr(ca(3, 'h00), 32'h0000_0000); wr(ca(3, 'h04), 9); wr(ca(3, 'h08), 6);
    chk("R8 idle level pol=1", int'(pwm_out[2]), 1);

    wr(12'h004, 32'h0000_000F);
    rd_exp(12'h00C, 32'h0000_000F, "R1 enable all");

    repeat (40) @(negedge clk);
    measure(0, 240, hi); chk("R7 ch0 duty 3/8", hi, 90);
    measure(1, 240, hi); chk("R7 ch1 prescale 1 duty 2/5", hi, 96);
    measure(2, 240, hi); chk("R8 ch2 inverted duty 1/4", hi, 180);
    measure(3, 240, hi); chk("R7 ch3 duty above period", hi, 240);

    // zero bits have no effect (R1, R2)
    wr(12'h004, 32'h0);
    rd_exp(12'h00C, 32'h0000_000F, "R1 zero write to enable");
    wr(12'h008, 32'h0);
    rd_exp(12'h00C, 32'h0000_000F, "R2 zero write to disable");
    wr(12'h008, 32'h0000_0005);
    rd_exp(12'h00C, 32'h0000_000A, "R2 disable ch0 ch2");
    repeat (3) @(negedge clk);
    chk("R10 ch0 idle low", int'(pwm_out[0]), 0);
    measure(2, 20, hi); chk("R10 ch2 idle high", hi, 20);

    // running channel ignores direct writes (R11)
    wr(ca(1, 'h04), 1);
    wr(ca(1, 'h00), 32'h0000_0203);
    rd_exp(ca(1, 'h04), 32'h2, "R11 duty frozen while running");
    rd_exp(ca(1, 'h00), 32'h1, "R11 mode frozen while running");

    // field widths and mode bits (R5, R6)
    wr(ca(0, 'h04), 32'hABCD_0004);
    rd_exp(ca(0, 'h04), 32'h0000_0004, "R5 duty upper bits dropped");
    wr(ca(0, 'h00), 32'hFFFF_F20F);
    rd_exp(ca(0, 'h00), 32'h0000_020A, "R6 prescale clamp and polarity");
    wr(ca(0, 'h00), 32'h0000_0404);
    rd_exp(ca(0, 'h00), 32'h0000_0404, "R6 target bit");

    // buffered duty update (R9)
    wr(ca(0, 'h00), 32'h0000_0004); wr(ca(0, 'h04), 2); wr(ca(0, 'h08), 10);
    wr(12'h004, 32'h1);
    wr(ca(0, 'h10), 7);
    wr(ca(0, 'h10), 5);
    rd_exp(ca(0, 'h04), 32'h2, "R9 duty unchanged before wrap");
    rd_exp(ca(0, 'h10), 32'h0, "R4 update reads zero");
    repeat (200) @(negedge clk);
    rd_exp(ca(0, 'h04), 32'h5, "R9 last pending duty applied");
    rd_exp(ca(0, 'h08), 32'hA, "R9 period untouched");

    // buffered period update (R9, R10 restart, R7 clamp)
    wr(12'h008, 32'h1);
    wr(ca(0, 'h00), 32'h0000_0400);
    wr(12'h004, 32'h1);
    wr(ca(0, 'h10), 4);
    repeat (30) @(negedge clk);
    rd_exp(ca(0, 'h08), 32'h4, "R9 period applied at wrap");
    rd_exp(ca(0, 'h04), 32'h5, "R9 duty kept on period update");
    measure(0, 40, hi); chk("R7 duty 5 over period 4", hi, 40);

    repeat (4) @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule